// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block produces the framing conditions of an I2C bus (start, stop, repeated start and the acknowledge clock) on two open-drain lines. A controller asks for one condition at a time with a one-clock command strobe. The sequencer then runs that condition as a chain of short steps. A prescaler sets the pace: it runs at most one step per tick, and one tick comes every `TICK_DIV` clocks. Each line is driven through an output-enable. Enable high pulls the line to zero. Enable low releases the line, and the pull-up raises it.

Both lines are read back through a two-flop synchronizer. A step that releases a line does not advance until the synchronized value reads high. This lets a slave stretch the clock, and the block waits for it with no limit. A start first checks that the bus is idle. If either line is low, it releases both lines and checks again. A repeated start runs its own head steps and then joins the last two steps of the start chain. Byte shifting, address handling, arbitration and timeouts belong to other blocks.

States: `ST_IDLE`; start `ST_START_CHK`, `ST_START_REL`, `ST_START_SDA`, `ST_START_SCL`; stop `ST_STOP_SDA`, `ST_STOP_SCL`, `ST_STOP_REL`; repeated start `ST_RS_SCL`, `ST_RS_SDA`, `ST_RS_SCLR`; acknowledge `ST_ACK_DRV`, `ST_ACK_REL`, `ST_ACK_END`. The transitions are:

- IDLE goes to START_CHK, STOP_SDA, RS_SCL or ACK_DRV when the matching strobe is accepted.
- START_CHK goes to START_SDA if both lines read high, and to START_REL if either reads low. START_REL goes back to START_CHK.
- START_SDA goes to START_SCL, and START_SCL goes to IDLE.
- STOP_SDA goes to STOP_SCL. STOP_SCL goes to STOP_REL once SCL reads high. STOP_REL goes to IDLE once SDA reads high.
- RS_SCL goes to RS_SDA. RS_SDA goes to RS_SCLR once SDA reads high. RS_SCLR goes to START_SDA once SCL reads high.
- ACK_DRV goes to ACK_REL. If the latched level is 1, it waits there until SDA reads high. ACK_REL goes to ACK_END once SCL reads high. ACK_END goes to IDLE.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset both output-enables are 0 (lines released), busy is 0 and done is 0. No output-enable changes while the block is idle.
- R2: Each step runs on a tick, and a tick comes every TICK_DIV clocks counted from reset. A released line is seen high only at the tick after the release, because of the two-flop synchronizer. The number of ticks from acceptance to done therefore depends only on the command and on the line levels at acceptance.
- R3: A start checks the idle bus first. If both lines read high, it drives SDA low on the next tick and SCL low on the tick after, then ends (3 ticks). If either line reads low, it releases both lines and checks again, and it keeps doing so until the bus is idle. It ends with scl_oe=1 and sda_oe=1.
- R4: A stop drives SDA low. It then releases SCL and waits for SCL high, then releases SDA and waits for SDA high. It ends with both output-enables 0 and produces exactly one stop event (SDA rising while SCL is high).
- R5: A repeated start drives SCL low. It then releases SDA and waits for SDA high, then releases SCL and waits for SCL high. It ends with the start tail (SDA low, then SCL low) and produces exactly one start event (SDA falling while SCL is high).
- R6: An acknowledge latches ack_level when the command is accepted. In its first step it drives SCL low. If the level is 0 it drives SDA low in the same step. If the level is 1 it releases SDA and waits for SDA high. It then releases SCL, waits for SCL high, and drives SCL low again. It ends with scl_oe=1 and sda_oe equal to the inverse of the latched level.
- R7: The wait steps have no timeout. While a slave holds SCL low during a stop, SDA stays driven low and done does not come.
- R8: Strobes are accepted only while idle. A strobe raised while busy has no effect. When strobes arrive together, start wins over stop, stop over repeated start, and repeated start over acknowledge.
- R9: busy is high from the clock after acceptance until the return to idle. done is high for exactly one clock, in the cycle where busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Strobe: generate a start condition |
| cmd_stop | input | 1 | Strobe: generate a stop condition |
| cmd_rstart | input | 1 | Strobe: generate a repeated start |
| cmd_ack | input | 1 | Strobe: generate an acknowledge clock |
| ack_level | input | 1 | SDA level for the acknowledge bit (0 = ACK, 1 = NACK), latched on acceptance |
| scl_in | input | 1 | Raw SCL level read from the pad |
| sda_in | input | 1 | Raw SDA level read from the pad |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release SCL |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release SDA |
| busy | output | 1 | A condition is in progress |
| done | output | 1 | One-clock pulse when the condition finishes |

## Verification
Each command is tried from every bus level that earlier commands leave behind. This matters because the number of ticks and the closing levels of a condition depend on which lines were low at acceptance. A two-tick difference shows whether a wait step really waits for the synchronized read-back. Directed cases cover the remaining behaviour:
- A slave holds SCL low during a stop. This shows whether the wait has no timeout and whether SDA is held.
- A slave holds SDA low before a start. This exercises the release-and-recheck loop.
- A strobe is raised mid-sequence. This shows whether a busy command is dropped.
- Strobes are raised together. This separates the priority order.
- ack_level is changed right after acceptance. This shows whether the level is latched.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_START_CHK = 4'd1,
        ST_START_REL = 4'd2,
        ST_START_SDA = 4'd3,
        ST_START_SCL = 4'd4,
        ST_STOP_SDA  = 4'd5,
        ST_STOP_SCL  = 4'd6,
        ST_STOP_REL  = 4'd7,
        ST_RS_SCL    = 4'd8,
        ST_RS_SDA    = 4'd9,
        ST_RS_SCLR   = 4'd10,
        ST_ACK_DRV   = 4'd11,
        ST_ACK_REL   = 4'd12,
        ST_ACK_END   = 4'd13
    } seq_state_t;

    localparam int LINE_CNT = 2;   // index 0 = SCL, 1 = SDA
    localparam int IDX_SCL  = 0;
    localparam int IDX_SDA  = 1;

endpackage

// File: rtl/i2c_step_tick.sv
module i2c_step_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '1;
                else        stg_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '1;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int TICK_DIV    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic cmd_rstart,
    input  logic cmd_ack,
    input  logic ack_level,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done
);
    logic                tick;
    logic [LINE_CNT-1:0] raw_lines;
    logic [LINE_CNT-1:0] seen_lines;
    logic                scl_hi;
    logic                sda_hi;

    seq_state_t state_q, state_d;
    logic       scl_oe_q, scl_oe_d;
    logic       sda_oe_q, sda_oe_d;
    logic       ackv_q, ackv_d;
    logic       done_q, done_d;

    i2c_step_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign raw_lines[IDX_SCL] = scl_in;
    assign raw_lines[IDX_SDA] = sda_in;

    i2c_line_sync #(.W(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .dout  (seen_lines)
    );

    assign scl_hi = seen_lines[IDX_SCL];
    assign sda_hi = seen_lines[IDX_SDA];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            ackv_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            scl_oe_q <= scl_oe_d;
            sda_oe_q <= sda_oe_d;
            ackv_q   <= ackv_d;
            done_q   <= done_d;
        end
    end

    // Step actions and next state
    always_comb begin
        state_d  = state_q;
        scl_oe_d = scl_oe_q;
        sda_oe_d = sda_oe_q;
        ackv_d   = ackv_q;
        done_d   = 1'b0;
        if (state_q == ST_IDLE) begin
            if (cmd_start) begin
                state_d = ST_START_CHK;
            end else if (cmd_stop) begin
                state_d = ST_STOP_SDA;
            end else if (cmd_rstart) begin
                state_d = ST_RS_SCL;
            end else if (cmd_ack) begin
                state_d = ST_ACK_DRV;
                ackv_d  = ack_level;
            end
        end else if (tick) begin
            unique case (state_q)
                ST_START_CHK: begin
                    state_d = (scl_hi && sda_hi) ? ST_START_SDA : ST_START_REL;
                end
                ST_START_REL: begin
                    scl_oe_d = 1'b0;
                    sda_oe_d = 1'b0;
                    state_d  = ST_START_CHK;
                end
                ST_START_SDA: begin
                    sda_oe_d = 1'b1;
                    state_d  = ST_START_SCL;
                end
                ST_START_SCL: begin
                    scl_oe_d = 1'b1;
                    state_d  = ST_IDLE;
                end
                ST_STOP_SDA: begin
                    sda_oe_d = 1'b1;
                    state_d  = ST_STOP_SCL;
                end
                ST_STOP_SCL: begin
                    scl_oe_d = 1'b0;
                    if (scl_hi) state_d = ST_STOP_REL;
                end
                ST_STOP_REL: begin
                    sda_oe_d = 1'b0;
                    if (sda_hi) state_d = ST_IDLE;
                end
                ST_RS_SCL: begin
                    scl_oe_d = 1'b1;
                    state_d  = ST_RS_SDA;
                end
                ST_RS_SDA: begin
                    sda_oe_d = 1'b0;
                    if (sda_hi) state_d = ST_RS_SCLR;
                end
                ST_RS_SCLR: begin
                    scl_oe_d = 1'b0;
                    if (scl_hi) state_d = ST_START_SDA;
                end
                ST_ACK_DRV: begin
                    scl_oe_d = 1'b1;
                    if (!ackv_q) begin
                        sda_oe_d = 1'b1;
                        state_d  = ST_ACK_REL;
                    end else begin
                        sda_oe_d = 1'b0;
                        if (sda_hi) state_d = ST_ACK_REL;
                    end
                end
                ST_ACK_REL: begin
                    scl_oe_d = 1'b0;
                    if (scl_hi) state_d = ST_ACK_END;
                end
                ST_ACK_END: begin
                    scl_oe_d = 1'b1;
                    state_d  = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
            done_d = (state_d == ST_IDLE);
        end
    end

    assign scl_oe = scl_oe_q;
    assign sda_oe = sda_oe_q;
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;

endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic cmd_stop,
    input logic cmd_rstart,
    input logic cmd_ack,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cmd_start || cmd_stop || cmd_rstart || cmd_ack)) |=> busy);

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_oe) || !$stable(sda_oe)) |-> $past(busy));

endmodule

bind i2c_cond_seq i2c_cond_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .cmd_rstart (cmd_rstart),
    .cmd_ack    (cmd_ack),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .done       (done)
);

// File: tb/i2c_cond_seq_test.sv
module i2c_cond_seq_test;
    localparam int DIV = 4;
    localparam int K_START = 0, K_STOP = 1, K_RSTART = 2, K_ACK = 3, K_BOTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_stop = 0, cmd_rstart = 0, cmd_ack = 0, ack_level = 0;
    logic scl_oe, sda_oe, busy, done;
    logic scl_bus, sda_bus, hold_scl, hold_sda;
    int   cyc = 0, scl_until = 0, sda_until = 0;
    int   total = 0, bad = 0;
    int   start_ev = 0, stop_ev = 0;
    bit   stretch_err = 0;
    logic p_scl = 1'b1, p_sda = 1'b1;

    always #10 clk = ~clk;

    assign hold_scl = (cyc < scl_until);
    assign hold_sda = (cyc < sda_until);
    assign scl_bus  = !(scl_oe || hold_scl);
    assign sda_bus  = !(sda_oe || hold_sda);

    i2c_cond_seq #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_rstart(cmd_rstart), .cmd_ack(cmd_ack),
        .ack_level(ack_level),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (p_sda && !sda_bus && p_scl && scl_bus) start_ev <= start_ev + 1;
        if (!p_sda && sda_bus && p_scl && scl_bus) stop_ev <= stop_ev + 1;
        if (hold_scl && !sda_oe) stretch_err <= 1'b1;
        p_scl <= scl_bus;
        p_sda <= sda_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ticks(input int kind, input bit lvl,
                                     input bit scl_lo, input bit sda_lo);
        case (kind)
            K_START, K_BOTH: return (scl_lo || sda_lo) ? 5 : 3;
            K_STOP:          return 1 + (scl_lo ? 2 : 1) + 2;
            K_RSTART:        return sda_lo ? 7 : 6;
            default:         return lvl ? ((sda_lo ? 2 : 1) + 3) : 4;
        endcase
    endfunction

    function automatic int exp_scl(input int kind);
        return (kind == K_STOP) ? 0 : 1;
    endfunction

    function automatic int exp_sda(input int kind, input bit lvl);
        if (kind == K_STOP) return 0;
        if (kind == K_ACK)  return lvl ? 0 : 1;
        return 1;
    endfunction

    // Issue one command, return clock edges from acceptance to done.
    task automatic run_cmd(input int kind, input bit lvl, input bit inject, output int k);
        @(negedge clk);
        cmd_start  = (kind == K_START) || (kind == K_BOTH);
        cmd_stop   = (kind == K_STOP)  || (kind == K_BOTH);
        cmd_rstart = (kind == K_RSTART);
        cmd_ack    = (kind == K_ACK);
        ack_level  = lvl;
        @(posedge clk);
        @(negedge clk);
        cmd_start = 0; cmd_rstart = 0; cmd_ack = 0;
        cmd_stop  = inject;
        ack_level = ~lvl;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        k = 0;
        while (!done && k < 3000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            cmd_stop = 0;
        end
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one clock", done, 0);
    endtask

    task automatic check_cmd(input int kind, input bit lvl, input string req);
        bit sl, dl;
        int n, k;
        sl = !scl_bus;
        dl = !sda_bus;
        n  = exp_ticks(kind, lvl, sl, dl);
        run_cmd(kind, lvl, 1'b0, k);
        chk(k >= (n - 1) * DIV + 1 && k <= n * DIV, {req, " R2 duration"}, k, n * DIV);
        chk(int'(scl_oe) == exp_scl(kind), {req, " final scl_oe"}, scl_oe, exp_scl(kind));
        chk(int'(sda_oe) == exp_sda(kind, lvl), {req, " final sda_oe"}, sda_oe, exp_sda(kind, lvl));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k, s0, p0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(scl_oe == 0, "R1 scl_oe", scl_oe, 0);
        chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        repeat (10) @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R1 idle quiet", {scl_oe, sda_oe}, 0);

        // R3 start on idle bus
        s0 = start_ev;
        check_cmd(K_START, 0, "R3 start");
        chk(start_ev - s0 == 1, "R3 start event", start_ev - s0, 1);
        // R6 acknowledge, both levels (level latched at acceptance)
        check_cmd(K_ACK, 0, "R6 ack0");
        check_cmd(K_ACK, 1, "R6 ack1");
        // R5 repeated start
        s0 = start_ev;
        check_cmd(K_RSTART, 0, "R5 rstart");
        chk(start_ev - s0 == 1, "R5 start event", start_ev - s0, 1);
        // R4 stop
        p0 = stop_ev;
        check_cmd(K_STOP, 0, "R4 stop");
        chk(stop_ev - p0 == 1, "R4 stop event", stop_ev - p0, 1);

        // R8 strobe while busy is dropped
        run_cmd(K_START, 0, 1'b1, k);
        repeat (10 * DIV) @(negedge clk);
        chk(busy == 0, "R8 busy strobe ignored busy", busy, 0);
        chk(scl_oe == 1 && sda_oe == 1, "R8 busy strobe ignored lines", {scl_oe, sda_oe}, 3);

        // R7 slave stretches SCL during stop
        scl_until = cyc + 60;
        run_cmd(K_STOP, 0, 1'b0, k);
        chk(k >= 60, "R7 waited for stretch", k, 60);
        chk(stretch_err == 0, "R7 SDA held while SCL low", stretch_err, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R7 stop final", {scl_oe, sda_oe}, 0);

        // R8 priority: start beats stop
        check_cmd(K_BOTH, 0, "R8 priority");

        // R3 busy bus: slave holds SDA low before a start
        check_cmd(K_STOP, 0, "R4 stop again");
        sda_until = cyc + 40;
        run_cmd(K_START, 0, 1'b0, k);
        chk(k >= 40, "R3 waits for idle bus", k, 40);
        chk(scl_oe == 1 && sda_oe == 1, "R3 start after recheck", {scl_oe, sda_oe}, 3);

        // R2 random command mix
        for (int i = 0; i < 40; i++) begin
            int kind;
            bit lvl;
            kind = int'($urandom % 4);
            lvl  = 1'($urandom % 2);
            check_cmd(kind, lvl, "R2 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule